// File: doc/BRIEF.md
# Addressed Eight-Channel Serial DAC Word Distributor

This block takes one serial data line and one shift clock from a host controller and routes each incoming 32-bit word to one of eight channel registers. A 3-bit channel address and one active-low select line choose the destination. The host interface is therefore six pins: data, clock, three address bits and select. Without the address it would need data, clock and eight separate selects. The host lines are asynchronous to the block clock. They pass through a synchronizer, and their edges are found in the block clock domain. Only the enable of the addressed channel is raised; the shift clock is never gated.

Each channel register fills MSB first. When its 32nd bit arrives, the completed word is copied into that channel's holding register. The held word goes to the DAC serial line only when the frame clock (LRCK) next changes level. From then on, each bit strobe moves it one place toward the output, MSB first. If a transfer stops before the 32nd bit, the holding register keeps its old word.

Top module: `dac_serial_distributor`

## Requirements
- R1: After reset every `dac_sdo` bit is 0 and every holding register holds zero, so the first LRCK change after reset sends 32 zero bits on every channel.
- R2: A 32-bit transfer with `host_csn` low is taken MSB first, one bit on each rising edge of `host_sclk`. It goes into the channel whose number equals `host_addr` read as an unsigned binary value (0 to 7). No other channel's holding register changes.
- R3: All eight address values reach their own distinct channel.
- R4: While `host_csn` is high, rising edges of `host_sclk` change no channel, whatever `host_addr` is.
- R5: The address is captured when `host_csn` falls. Changing `host_addr` while `host_csn` stays low does not redirect the rest of the transfer.
- R6: A transfer that ends (`host_csn` high) after fewer than 32 bits leaves the holding register unchanged. The next transfer starts again from bit 31.
- R7: A newly committed word does not show on `dac_sdo` until the next LRCK level change. Both rising and falling LRCK changes load every channel's output register.
- R8: After an LRCK change, `dac_sdo[n]` shows bit 31 of channel n's held word. Each `bit_tick` cycle moves on to the next lower bit. After 32 ticks the line reads 0.
- R9: More than 32 bits in one select window commit each full 32-bit group in turn, so the held word is the last complete group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sclk | input | 1 | Host shift clock (asynchronous) |
| host_sdi | input | 1 | Host serial data, MSB first |
| host_csn | input | 1 | Active-low select / inhibit |
| host_addr | input | 3 | Destination channel number |
| frame_lrck | input | 1 | Frame clock, synchronous to clk; any level change loads outputs |
| bit_tick | input | 1 | One-cycle strobe advancing the DAC serial outputs |
| dac_sdo | output | 8 | Serial data to the eight DACs, bit n for channel n |

## Verification
A wrong address latch or decode puts a word in the wrong channel. A wrong bit counter commits a word that is shifted out of place or a truncated one. Neither can be seen until the next LRCK change and the 32 ticks that follow it. The bench therefore follows every transfer with a full read-out of all eight channels and compares 256 bits against its own model. A faulty output register shows up within one strobe of the load, as a wrong MSB or a missing zero fill after the last bit.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

   // Host-side control bits that travel through the synchronizer together.
   typedef struct packed {
      logic sclk;
      logic sdi;
      logic csn;
   } host_ctl_t;

   localparam int HOST_CTL_W = $bits(host_ctl_t);

   // Idle level of the host control bits, applied while in reset.
   localparam host_ctl_t HOST_CTL_IDLE = '{sclk: 1'b0, sdi: 1'b0, csn: 1'b1};

   function automatic bit is_pow2(input int value);
      return (value >= 2) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/dsd_sync.sv
module dsd_sync #(
   parameter int                WIDTH    = 4,
   parameter int                STAGES   = 2,
   parameter logic [WIDTH-1:0]  IDLE_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   initial begin
      stages_range_chk : assert (STAGES >= 1 && STAGES <= 4)
         else $error("dsd_sync: STAGES must be 1..4");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= IDLE_VAL;
            else        stage_q[0] <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stage_q[s] <= IDLE_VAL;
            end else begin
               stage_q[0] <= din;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/dsd_addr_ctrl.sv
module dsd_addr_ctrl #(
   parameter int NUM_CH = 8,
   parameter int WORD_W = 32,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int CNT_W  = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn_s,
   input  logic              sclk_rise,
   input  logic [ADDR_W-1:0] addr_s,
   output logic              csn_fall,
   output logic [ADDR_W-1:0] sel_addr,
   output logic [NUM_CH-1:0] shift_en,
   output logic [NUM_CH-1:0] commit
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   logic              csn_prev;
   logic [CNT_W-1:0]  bit_cnt;
   logic [CNT_W-1:0]  cnt_eff;
   logic [ADDR_W-1:0] addr_eff;
   logic              take_bit;
   logic              word_done;

   assign csn_fall  = csn_prev & ~csn_s;
   // On the select edge itself the freshly sampled address and a cleared
   // count apply, so a clock rise in that same cycle is not misrouted.
   assign addr_eff  = csn_fall ? addr_s : sel_addr;
   assign cnt_eff   = csn_fall ? '0 : bit_cnt;
   assign take_bit  = ~csn_s & sclk_rise;
   assign word_done = take_bit & (cnt_eff == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_prev <= 1'b1;
         sel_addr <= '0;
         bit_cnt  <= '0;
      end else begin
         csn_prev <= csn_s;
         if (csn_fall) sel_addr <= addr_s;
         if (take_bit) bit_cnt <= word_done ? '0 : cnt_eff + 1'b1;
         else if (csn_fall) bit_cnt <= '0;
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
         logic hit;
         assign hit         = (addr_eff == ADDR_W'(c));
         assign shift_en[c] = take_bit  & hit;
         assign commit[c]   = word_done & hit;
      end
   endgenerate

endmodule

// File: rtl/dsd_channel.sv
module dsd_channel #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              commit,
   input  logic              sdi_s,
   input  logic              lrck_edge,
   input  logic              bit_tick,
   output logic [WORD_W-1:0] hold,
   output logic              sdo
);

   logic [WORD_W-1:0] in_sr;
   logic [WORD_W-1:0] out_sr;
   logic [WORD_W-1:0] in_next;

   assign in_next = {in_sr[WORD_W-2:0], sdi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_sr  <= '0;
         hold   <= '0;
         out_sr <= '0;
      end else begin
         if (shift_en) in_sr <= in_next;
         if (commit)   hold  <= in_next;
         if (lrck_edge)     out_sr <= hold;
         else if (bit_tick) out_sr <= {out_sr[WORD_W-2:0], 1'b0};
      end
   end

   assign sdo = out_sr[WORD_W-1];

endmodule

// File: rtl/dac_serial_distributor.sv
module dac_serial_distributor #(
   parameter int NUM_CH      = 8,
   parameter int WORD_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sclk,
   input  logic              host_sdi,
   input  logic              host_csn,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              frame_lrck,
   input  logic              bit_tick,
   output logic [NUM_CH-1:0] dac_sdo
);
   import dsd_pkg::*;

   localparam int SYNC_W = HOST_CTL_W + ADDR_W;
   localparam logic [SYNC_W-1:0] SYNC_IDLE = {HOST_CTL_IDLE, {ADDR_W{1'b0}}};

   initial begin
      ch_count_chk : assert (is_pow2(NUM_CH))
         else $error("NUM_CH must be a power of two, at least 2");
      word_width_chk : assert (WORD_W >= 2)
         else $error("WORD_W must be at least 2");
   end

   // Host pins
   host_ctl_t         ctl_s;
   logic [ADDR_W-1:0] addr_s;
   logic [SYNC_W-1:0] sync_out;

   dsd_sync #(
      .WIDTH    (SYNC_W),
      .STAGES   (SYNC_STAGES),
      .IDLE_VAL (SYNC_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({host_sclk, host_sdi, host_csn, host_addr}),
      .dout  (sync_out)
   );

   assign ctl_s  = host_ctl_t'(sync_out[SYNC_W-1:ADDR_W]);
   assign addr_s = sync_out[ADDR_W-1:0];

   logic sclk_prev;
   logic sclk_rise;
   logic lrck_prev;
   logic lrck_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         lrck_prev <= 1'b0;
      end else begin
         sclk_prev <= ctl_s.sclk;
         lrck_prev <= frame_lrck;
      end
   end

   assign sclk_rise = ctl_s.sclk & ~sclk_prev;
   assign lrck_edge = frame_lrck ^ lrck_prev;

   // Address and word control
   logic              csn_s;
   logic              csn_fall;
   logic [ADDR_W-1:0] sel_addr;
   logic [NUM_CH-1:0] shift_en;
   logic [NUM_CH-1:0] commit;

   assign csn_s = ctl_s.csn;

   dsd_addr_ctrl #(
      .NUM_CH (NUM_CH),
      .WORD_W (WORD_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .csn_s     (csn_s),
      .sclk_rise (sclk_rise),
      .addr_s    (addr_s),
      .csn_fall  (csn_fall),
      .sel_addr  (sel_addr),
      .shift_en  (shift_en),
      .commit    (commit)
   );

   // Channels
   logic [NUM_CH*WORD_W-1:0] hold_flat;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         dsd_channel #(
            .WORD_W (WORD_W)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (shift_en[c]),
            .commit    (commit[c]),
            .sdi_s     (ctl_s.sdi),
            .lrck_edge (lrck_edge),
            .bit_tick  (bit_tick),
            .hold      (hold_flat[c*WORD_W +: WORD_W]),
            .sdo       (dac_sdo[c])
         );
      end
   endgenerate

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
   parameter int NUM_CH = 8,
   parameter int WORD_W = 32,
   localparam int ADDR_W = $clog2(NUM_CH)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     csn_s,
   input logic                     csn_fall,
   input logic [ADDR_W-1:0]        sel_addr,
   input logic [NUM_CH-1:0]        shift_en,
   input logic [NUM_CH-1:0]        commit,
   input logic [NUM_CH*WORD_W-1:0] hold_flat,
   input logic                     frame_lrck,
   input logic                     bit_tick,
   input logic [NUM_CH-1:0]        dac_sdo
);

   // R2
   single_target_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(shift_en));

   // R2
   shift_follows_latch_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en != '0 && !csn_fall) |-> shift_en[sel_addr]);

   // R4
   inhibit_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> $stable(hold_flat));

   // R5
   addr_stable_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !csn_fall |=> $stable(sel_addr));

   // R6
   commit_needs_shift_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (commit != '0) |-> (commit == shift_en));

   // R7
   output_quiet_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(frame_lrck) && !bit_tick) |=> $stable(dac_sdo));

endmodule

bind dac_serial_distributor dsd_checker #(
   .NUM_CH (NUM_CH),
   .WORD_W (WORD_W)
) u_dsd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .csn_s      (csn_s),
   .csn_fall   (csn_fall),
   .sel_addr   (sel_addr),
   .shift_en   (shift_en),
   .commit     (commit),
   .hold_flat  (hold_flat),
   .frame_lrck (frame_lrck),
   .bit_tick   (bit_tick),
   .dac_sdo    (dac_sdo)
);

// File: tb/dac_serial_distributor_test.sv
module dac_serial_distributor_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCLK  = 4;
   localparam int NCH        = 8;
   localparam int WW         = 32;
   localparam int NVEC       = 8;

   // Vector: {address[2:0], word[31:0]}
   localparam logic [34:0] VECS [NVEC] = '{
      {3'd0, 32'hA5A5_0001},
      {3'd1, 32'h8000_0001},
      {3'd2, 32'h1234_5678},
      {3'd3, 32'hFFFF_FFFF},
      {3'd4, 32'h0F0F_F0F0},
      {3'd5, 32'hDEAD_BEEF},
      {3'd6, 32'h7FFF_FFFE},
      {3'd7, 32'hC001_D00D}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           host_sclk = 1'b0;
   logic           host_sdi = 1'b0;
   logic           host_csn = 1'b1;
   logic [2:0]     host_addr = '0;
   logic           frame_lrck = 1'b0;
   logic           bit_tick = 1'b0;
   logic [NCH-1:0] dac_sdo;

   int total = 0;
   int bad   = 0;

   logic [WW-1:0] model [NCH];
   logic [WW-1:0] got   [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_serial_distributor uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_sclk  (host_sclk),
      .host_sdi   (host_sdi),
      .host_csn   (host_csn),
      .host_addr  (host_addr),
      .frame_lrck (frame_lrck),
      .bit_tick   (bit_tick),
      .dac_sdo    (dac_sdo)
   );

   task automatic check(input string req, input logic [WW-1:0] act,
                        input logic [WW-1:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Drives nbits host bits MSB first; optionally moves the address mid-way.
   task automatic send(input logic [2:0] addr, input logic [63:0] data,
                       input int nbits, input int swap_at, input logic [2:0] swap_addr);
      @(negedge clk);
      host_addr = addr;
      wait_clks(HALF_SCLK);
      host_csn = 1'b0;
      wait_clks(HALF_SCLK);
      for (int i = 0; i < nbits; i++) begin
         if (i == swap_at) host_addr = swap_addr;
         host_sdi  = data[nbits-1-i];
         host_sclk = 1'b0;
         wait_clks(HALF_SCLK);
         host_sclk = 1'b1;
         wait_clks(HALF_SCLK);
      end
      host_sclk = 1'b0;
      wait_clks(HALF_SCLK);
      host_csn = 1'b1;
      wait_clks(3 * HALF_SCLK);
   endtask

   // Toggle LRCK and capture 32 bits of every channel; then check zero fill.
   task automatic read_all(input string req);
      @(negedge clk);
      frame_lrck = ~frame_lrck;
      @(negedge clk);
      for (int b = WW - 1; b >= 0; b--) begin
         for (int c = 0; c < NCH; c++) got[c][b] = dac_sdo[c];
         bit_tick = 1'b1;
         @(negedge clk);
         bit_tick = 1'b0;
      end
      // R8: after the last bit the line reads zero
      check("R8", WW'(dac_sdo), '0, "zero fill after 32 ticks");
      for (int c = 0; c < NCH; c++)
         check(req, got[c], model[c], $sformatf("channel %0d word", c));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      for (int c = 0; c < NCH; c++) model[c] = '0;
      wait_clks(5);
      // R1: outputs low in reset
      check("R1", WW'(dac_sdo), '0, "sdo during reset");
      rst_n = 1'b1;
      wait_clks(5);
      check("R1", WW'(dac_sdo), '0, "sdo after reset");
      read_all("R1");

      // R2 R3: table walk, each address in turn (LRCK alternates: R7 both edges)
      for (int v = 0; v < NVEC; v++) begin
         send(VECS[v][34:32], {32'h0, VECS[v][31:0]}, WW, -1, 3'd0);
         model[VECS[v][34:32]] = VECS[v][31:0];
         read_all(v % 2 == 0 ? "R2" : "R3");
      end

      // R4: clock pulses with select inactive are ignored
      @(negedge clk);
      host_addr = 3'd0;
      for (int i = 0; i < 40; i++) begin
         host_sdi  = ~host_sdi;
         host_sclk = 1'b1;
         wait_clks(HALF_SCLK);
         host_sclk = 1'b0;
         host_addr = host_addr + 3'd1;
         wait_clks(HALF_SCLK);
      end
      read_all("R4");

      // R5: address moved mid-transfer, word still lands in channel 2
      send(3'd2, {32'h0, 32'h5A5A_C3C3}, WW, 10, 3'd5);
      model[2] = 32'h5A5A_C3C3;
      read_all("R5");

      // R6: short transfer leaves channel 3 unchanged
      send(3'd3, {54'h0, 10'h2AA}, 10, -1, 3'd0);
      read_all("R6");
      // R6: following full transfer starts fresh
      send(3'd3, {32'h0, 32'h0BAD_F00D}, WW, -1, 3'd0);
      model[3] = 32'h0BAD_F00D;
      read_all("R6");

      // R7: new word not visible before the LRCK change (outputs drained)
      send(3'd6, {32'h0, 32'hFFFF_0000}, WW, -1, 3'd0);
      model[6] = 32'hFFFF_0000;
      wait_clks(20);
      check("R7", WW'(dac_sdo[6]), '0, "channel 6 before LRCK change");
      read_all("R7");

      // R9: 64 bits in one window, second word is kept
      send(3'd4, {32'h1111_2222, 32'h3333_4444}, 2 * WW, -1, 3'd0);
      model[4] = 32'h3333_4444;
      read_all("R9");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule